// File: doc/BRIEF.md
# Software Write-Protect Command Sequencer

This block decodes commands for a byte-wide nonvolatile memory with page programming. It sees every latched byte load, meaning a one-cycle strobe with the low address bits and the data byte. It picks out the multi-byte unlock sequences and classifies every other byte as either page data or a rejected write.

It holds one global protect flag, which is clear after reset. The three-byte write-open sequence sets that flag and opens a window for one page load. The window closes when the array controller starts its internal cycle, and protection stays on afterwards. Two six-byte sequences clear protection or start a full-array erase. Two three-byte sequences enter and leave an identification mode, in which reads return the manufacturer and device codes.

A data byte that arrives while protection is on and no window is open is rejected. That rejection starts a timed lockout, during which every byte load is ignored. Byte loads are also ignored while the array controller reports an internal write or erase cycle.

Top module: `wp_cmd_seq`

## Requirements
- R1: After a synchronous active-low reset, protect, id_mode, lockout, wr_permit, erase_go and rd_id_valid are all 0.
- R2: While unprotected, a byte load that is not part of a command sequence gives wr_permit high for the one cycle after the strobe.
- R3: The loads AAh at 5555h, 55h at 2AAAh, A0h at 5555h set protect, with addresses compared on the low 15 bits. Every following byte load then gives a wr_permit pulse, until cyc_busy is seen high. Protect stays set after that.
- R4: While protected with no window open, a byte load that is not a command byte gives no wr_permit. It raises lockout from the next cycle for exactly LOCK_CYC cycles.
- R5: Byte loads during lockout or while cyc_busy is high have no effect. They give no wr_permit and do not advance or reset a command sequence.
- R6: The loads AAh/5555h, 55h/2AAAh, 80h/5555h, AAh/5555h, 55h/2AAAh, 20h/5555h clear protect one cycle after the last strobe.
- R7: The same six-byte prefix ending in 10h at 5555h gives erase_go high for exactly one cycle after the last strobe, and leaves protect unchanged.
- R8: AAh/5555h, 55h/2AAAh, 90h/5555h sets id_mode. The same prefix ending in F0h at 5555h clears it.
- R9: A read request gives rd_id_valid in the next cycle exactly when id_mode is set. rd_id_data is then BFh for address 0 and DEV_CODE for address 1.
- R10: A byte that does not match the next expected step sends the matcher back to idle, and it is classified as an ordinary byte load. A later 55h/2AAAh, A0h/5555h therefore does not complete write-open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_stb | input | 1 | One-cycle byte-load strobe |
| ld_addr | input | 15 | Low address bits of the byte load |
| ld_data | input | 8 | Data byte of the load |
| cyc_busy | input | 1 | Internal write or erase cycle in progress |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| protect | output | 1 | Global protect flag |
| wr_permit | output | 1 | Pulse: previous byte load is accepted as page data |
| erase_go | output | 1 | Pulse: start full-array erase |
| id_mode | output | 1 | Identification mode active |
| lockout | output | 1 | Rejected-write lockout in progress |
| rd_id_valid | output | 1 | Identification byte on rd_id_data |
| rd_id_data | output | 8 | Identification byte |

## Verification
The assertions assume two things about the inputs. First, cyc_busy rises only after the page load it ends. Second, ld_stb marks single byte loads rather than a level held across many cycles. The bench drives each strobe high for exactly one cycle, between falling edges. It raises cyc_busy only between byte loads, except where it deliberately holds cyc_busy high over loads to check that they are ignored. Lockout is started only by a rejected byte while no lockout is running, and the stimulus waits for lockout to end before it sends further commands.

// File: rtl/wp_cmd_pkg.sv
// Package for the write-protect command sequencer.
// Holds the matcher state type, the byte-classification type and the command codes.
package wp_cmd_pkg;
    localparam int CMD_AW = 15;
    localparam logic [CMD_AW-1:0] UNLK_A1 = 15'h5555;
    localparam logic [CMD_AW-1:0] UNLK_A2 = 15'h2AAA;
    localparam logic [7:0] UNLK_D1  = 8'hAA;
    localparam logic [7:0] UNLK_D2  = 8'h55;
    localparam logic [7:0] OP_OPEN  = 8'hA0;
    localparam logic [7:0] OP_IDIN  = 8'h90;
    localparam logic [7:0] OP_IDOUT = 8'hF0;
    localparam logic [7:0] OP_LONG  = 8'h80;
    localparam logic [7:0] OP_UNPR  = 8'h20;
    localparam logic [7:0] OP_ERASE = 8'h10;
    localparam logic [7:0] MFR_CODE = 8'hBF;

    typedef enum logic [2:0] {
        M_IDLE, M_U1, M_U2, M_X3, M_X4, M_X5
    } mstate_t;

    typedef enum logic [2:0] {
        K_PART, K_OPEN, K_IDIN, K_IDOUT, K_UNPROT, K_ERASE, K_DATA
    } kind_t;
endpackage

// File: rtl/wp_seq_match.sv
// Unlock-sequence matcher.
// Classifies the byte load on the current cycle from the matcher state and the byte.
// It advances only when en is high. Assumes en is already gated by lockout, busy and open window.
module wp_seq_match
    import wp_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CMD_AW-1:0] addr,
    input  logic [7:0]        data,
    output kind_t             kind
);
    mstate_t st_q, st_d;
    logic    at_a1, at_a2;

    assign at_a1 = (addr == UNLK_A1);
    assign at_a2 = (addr == UNLK_A2);

    // Classify the current byte and choose the next matcher state.
    always_comb begin
        kind = K_DATA;
        st_d = M_IDLE;
        case (st_q)
            M_IDLE: if (at_a1 && data == UNLK_D1) begin kind = K_PART; st_d = M_U1; end
            M_U1:   if (at_a2 && data == UNLK_D2) begin kind = K_PART; st_d = M_U2; end
            M_U2:   if (at_a1) begin
                        case (data)
                            OP_OPEN:  kind = K_OPEN;
                            OP_IDIN:  kind = K_IDIN;
                            OP_IDOUT: kind = K_IDOUT;
                            OP_LONG:  begin kind = K_PART; st_d = M_X3; end
                            default:  kind = K_DATA;
                        endcase
                    end
            M_X3:   if (at_a1 && data == UNLK_D1) begin kind = K_PART; st_d = M_X4; end
            M_X4:   if (at_a2 && data == UNLK_D2) begin kind = K_PART; st_d = M_X5; end
            M_X5:   if (at_a1) begin
                        case (data)
                            OP_UNPR:  kind = K_UNPROT;
                            OP_ERASE: kind = K_ERASE;
                            default:  kind = K_DATA;
                        endcase
                    end
            default: st_d = M_IDLE;
        endcase
    end

    // Matcher state register.
    always_ff @(posedge clk) begin
        if (!rst_n)  st_q <= M_IDLE;
        else if (en) st_q <= st_d;
    end

    // R10: a non-command byte always returns the matcher to idle
    a_r10_break_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (en && kind == K_DATA) |=> (st_q == M_IDLE));
endmodule

// File: rtl/wp_lock_timer.sv
// Rejected-write lockout timer.
// A start pulse holds lockout high for LOCK_CYC cycles, beginning on the next cycle.
// Assumes start never arrives while lockout is already high.
module wp_lock_timer #(
    parameter int LOCK_CYC = 15000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic lockout
);
    localparam int CNT_W = $clog2(LOCK_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(LOCK_CYC);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (start)      cnt_q <= LOAD;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign lockout = (cnt_q != 0);

    // R5: gating upstream must keep a start from arriving during a lockout
    a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |-> !start);
endmodule

// File: rtl/wp_id_read.sv
// Identification read path.
// While id_mode is set, a read request returns the manufacturer code at address 0 and DEV_CODE at address 1, one cycle later.
// Any other address returns 00h.
module wp_id_read
    import wp_cmd_pkg::*;
#(
    parameter int         ADDR_W   = 17,
    parameter logic [7:0] DEV_CODE = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_mode,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_id_valid,
    output logic [7:0]        rd_id_data
);
    logic [7:0] sel;

    // Pick the identification byte for the requested address.
    always_comb begin
        if (rd_addr == ADDR_W'(0))      sel = MFR_CODE;
        else if (rd_addr == ADDR_W'(1)) sel = DEV_CODE;
        else                            sel = 8'h00;
    end

    // Register the steered read result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_id_valid <= 1'b0;
            rd_id_data  <= 8'h00;
        end else begin
            rd_id_valid <= rd_req && id_mode;
            rd_id_data  <= (rd_req && id_mode) ? sel : 8'h00;
        end
    end

    // R9: identification data only answers a request
    a_r9_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_id_valid |-> $past(rd_req));
endmodule

// File: rtl/wp_cmd_seq.sv
// Software write-protect command sequencer (top).
// Gates byte loads by busy and lockout, and runs the matcher outside an open write window.
// Keeps the protect, window and ID flags, and issues the permit and erase pulses.
// Assumes cyc_busy comes from the array controller and rises only after a page load.
module wp_cmd_seq
    import wp_cmd_pkg::*;
#(
    parameter int         ADDR_W   = 17,
    parameter int         LOCK_CYC = 15000,
    parameter logic [7:0] DEV_CODE = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_stb,
    input  logic [CMD_AW-1:0] ld_addr,
    input  logic [7:0]        ld_data,
    input  logic              cyc_busy,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              protect,
    output logic              wr_permit,
    output logic              erase_go,
    output logic              id_mode,
    output logic              lockout,
    output logic              rd_id_valid,
    output logic [7:0]        rd_id_data
);
    logic  eff_stb, m_en, lock_start, open_q;
    kind_t kind;

    assign eff_stb    = ld_stb && !cyc_busy && !lockout;
    assign m_en       = eff_stb && !open_q;
    assign lock_start = m_en && (kind == K_DATA) && protect;

    wp_seq_match u_match (
        .clk(clk), .rst_n(rst_n), .en(m_en),
        .addr(ld_addr), .data(ld_data), .kind(kind)
    );

    wp_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk(clk), .rst_n(rst_n), .start(lock_start), .lockout(lockout)
    );

    wp_id_read #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_id (
        .clk(clk), .rst_n(rst_n), .id_mode(id_mode), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_id_valid(rd_id_valid), .rd_id_data(rd_id_data)
    );

    // Update the mode flags and pulses from the classified byte load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            protect   <= 1'b0;
            open_q    <= 1'b0;
            id_mode   <= 1'b0;
            wr_permit <= 1'b0;
            erase_go  <= 1'b0;
        end else begin
            wr_permit <= 1'b0;
            erase_go  <= 1'b0;
            if (cyc_busy) open_q <= 1'b0;
            if (eff_stb && open_q) begin
                wr_permit <= 1'b1;
            end else if (m_en) begin
                case (kind)
                    K_OPEN:   begin protect <= 1'b1; open_q <= 1'b1; end
                    K_IDIN:   id_mode  <= 1'b1;
                    K_IDOUT:  id_mode  <= 1'b0;
                    K_UNPROT: protect  <= 1'b0;
                    K_ERASE:  erase_go <= 1'b1;
                    K_DATA:   if (!protect) wr_permit <= 1'b1;
                    default:  ;
                endcase
            end
        end
    end

    // R4: a rejected write never also yields a permit
    a_r4_lock_no_permit: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |-> !wr_permit);
    // R5: nothing is accepted while the array is busy
    a_r5_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_busy |=> (!wr_permit && !erase_go));
    // R3: protection is only set by a byte load
    a_r3_prot_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(protect) |-> $past(ld_stb && !cyc_busy));
    // R6: protection is only cleared by an accepted byte load
    a_r6_prot_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(protect) |-> $past(ld_stb && !lockout));
    // R7: erase start is a single-cycle pulse
    a_r7_erase_one: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> !erase_go);
endmodule

// File: tb/tb_wp_cmd_seq.sv
`timescale 1ns/1ps
module tb_wp_cmd_seq;
    localparam int         LOCK = 20;
    localparam logic [7:0] DEV  = 8'h08;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_stb = 1'b0;
    logic [14:0] ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic        cyc_busy = 1'b0;
    logic        rd_req = 1'b0;
    logic [16:0] rd_addr = '0;
    logic        protect, wr_permit, erase_go, id_mode, lockout, rd_id_valid;
    logic [7:0]  rd_id_data;

    int total = 0;
    int fails = 0;

    wp_cmd_seq #(.ADDR_W(17), .LOCK_CYC(LOCK), .DEV_CODE(DEV)) dut (
        .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_addr(ld_addr),
        .ld_data(ld_data), .cyc_busy(cyc_busy), .rd_req(rd_req),
        .rd_addr(rd_addr), .protect(protect), .wr_permit(wr_permit),
        .erase_go(erase_go), .id_mode(id_mode), .lockout(lockout),
        .rd_id_valid(rd_id_valid), .rd_id_data(rd_id_data)
    );

    always #10 clk = ~clk;

    // Fields: pre(2) addr(15) data(8) permit prot lock.
    // pre: 0 none, 1 busy pulse before the load, 2 wait for lockout to end.
    localparam int NV = 18;
    localparam logic [27:0] VEC [NV] = '{
        {2'd0, 15'h0100, 8'h12, 1'b1, 1'b0, 1'b0},  // R2 plain data while unprotected
        {2'd0, 15'h5555, 8'hAA, 1'b0, 1'b0, 1'b0},  // R3 step 1
        {2'd0, 15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0},  // R3 step 2
        {2'd0, 15'h5555, 8'hA0, 1'b0, 1'b1, 1'b0},  // R3 protect set
        {2'd0, 15'h0200, 8'h33, 1'b1, 1'b1, 1'b0},  // R3 window data
        {2'd0, 15'h0201, 8'h34, 1'b1, 1'b1, 1'b0},  // R3 window data
        {2'd1, 15'h0300, 8'h55, 1'b0, 1'b1, 1'b1},  // R4 window closed, blocked
        {2'd0, 15'h0301, 8'h66, 1'b0, 1'b1, 1'b1},  // R5 ignored in lockout
        {2'd2, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0},  // R6 step 1
        {2'd0, 15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0},  // R6 step 2
        {2'd0, 15'h5555, 8'h80, 1'b0, 1'b1, 1'b0},  // R6 step 3
        {2'd0, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0},  // R6 step 4
        {2'd0, 15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0},  // R6 step 5
        {2'd0, 15'h5555, 8'h20, 1'b0, 1'b0, 1'b0},  // R6 protect cleared
        {2'd0, 15'h5555, 8'hAA, 1'b0, 1'b0, 1'b0},  // R10 start
        {2'd0, 15'h0123, 8'h77, 1'b1, 1'b0, 1'b0},  // R10 break byte is data
        {2'd0, 15'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0},  // R10 from idle, data
        {2'd0, 15'h5555, 8'hA0, 1'b1, 1'b0, 1'b0}   // R10 no write-open
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One-cycle byte load, then sample in the cycle after the strobe edge.
    task automatic do_ld(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_stb = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_stb = 1'b0;
    endtask

    task automatic pre3();
        do_ld(15'h5555, 8'hAA);
        do_ld(15'h2AAA, 8'h55);
    endtask

    task automatic do_rd(input logic [16:0] a);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic busy_pulse();
        @(negedge clk); cyc_busy = 1'b1;
        repeat (3) @(negedge clk);
        cyc_busy = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 protect", protect, 0);
        chk("R1 id_mode", id_mode, 0);
        chk("R1 lockout", lockout, 0);
        chk("R1 wr_permit", wr_permit, 0);
        chk("R1 erase_go", erase_go, 0);
        chk("R1 rd_id_valid", rd_id_valid, 0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][27:26] == 2'd1) busy_pulse();
            if (VEC[i][27:26] == 2'd2) while (lockout) @(negedge clk);
            do_ld(VEC[i][25:11], VEC[i][10:3]);
            chk($sformatf("vec%0d permit", i), wr_permit, VEC[i][2]);
            chk($sformatf("vec%0d protect", i), protect, VEC[i][1]);
            chk($sformatf("vec%0d lockout", i), lockout, VEC[i][0]);
        end

        // R5 loads while busy are ignored and do not advance the matcher
        cyc_busy = 1'b1;
        pre3();
        do_ld(15'h5555, 8'hA0);
        chk("R5 busy permit", wr_permit, 0);
        chk("R5 busy protect", protect, 0);
        cyc_busy = 1'b0;
        do_ld(15'h5555, 8'hA0);
        chk("R5 after busy plain data", wr_permit, 1);
        chk("R5 after busy protect", protect, 0);

        // R4 lockout length
        pre3();
        do_ld(15'h5555, 8'hA0);
        chk("R3 protect set again", protect, 1);
        busy_pulse();
        do_ld(15'h0444, 8'h01);
        n = 0;
        while (lockout && n < 1000) begin n++; @(negedge clk); end
        chk("R4 lockout cycles", n, LOCK);

        // R7 erase pulse, protection kept
        pre3();
        do_ld(15'h5555, 8'h80);
        pre3();
        do_ld(15'h5555, 8'h10);
        chk("R7 erase_go high", erase_go, 1);
        chk("R7 no lockout", lockout, 0);
        @(negedge clk);
        chk("R7 erase_go one cycle", erase_go, 0);
        chk("R7 protect unchanged", protect, 1);

        // R8 and R9 identification mode
        do_rd(17'd0);
        chk("R9 no id when off", rd_id_valid, 0);
        pre3();
        do_ld(15'h5555, 8'h90);
        chk("R8 id entry", id_mode, 1);
        chk("R8 entry no lockout", lockout, 0);
        do_rd(17'd0);
        chk("R9 valid addr0", rd_id_valid, 1);
        chk("R9 mfr code", rd_id_data, 8'hBF);
        do_rd(17'd1);
        chk("R9 dev code", rd_id_data, DEV);
        pre3();
        do_ld(15'h5555, 8'hF0);
        chk("R8 id exit", id_mode, 0);
        do_rd(17'd1);
        chk("R9 no id after exit", rd_id_valid, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule